// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block moves data for a single channel by walking a chain of descriptors kept in memory. Each descriptor is three consecutive 32-bit words. The first is the buffer address, the second is a count and flag word, and the third points at the next descriptor. The engine reads descriptors and buffer words through a word-wide memory master port. It streams buffer bytes out on a transmit byte port, or gathers bytes from a receive byte port and writes them into the buffer. When a buffer is finished, the engine writes a status bit back into the descriptor's count word. It can also raise an interrupt, and it either stops or follows the chain to the next descriptor.

Software writes the address of the first descriptor into the next-descriptor register. It then writes the control register with the start bit set, together with the byte order and the direction. While the chain is being walked, the status register reports the channel as busy, and the next-descriptor register tracks the chain. A channel-reset bit aborts the transfer, and a separate bit clears a pending interrupt.

Top module: `desc_dma`

## Requirements
- R1: A descriptor at address D is read as three words: the buffer address from D, the count/flag word from D+4 and the next pointer from D+8. All three are fetched before any buffer data moves. Bits 13:0 of the count/flag word give the buffer length in bytes.
- R2: Register 0 holds the next-descriptor pointer. Software can write it only while the channel is idle. Writing register 1 with bit 0 set, while idle, starts the chain at that pointer. Status bit 0 (busy), read from register 1, stays 1 until the chain ends.
- R3: On transmit, buffer words are read in turn from the buffer address upward. Control bit 1 selects the byte order: 0 sends bits 31:24 of each word first, and 1 sends bits 7:0 first. A presented byte is held until the device accepts it.
- R4: The end-of-packet output is raised together with the final byte of a buffer, and only when bit 30 of that descriptor's count/flag word is set. It is never raised with any other byte.
- R5: When bit 31 of the count/flag word is set, the engine stops after that buffer and busy returns to 0. Otherwise it continues at the next pointer. After each descriptor, register 0 reads that descriptor's next pointer.
- R6: When bit 29 is set, the interrupt output rises once the descriptor is finished. It stays high until software writes register 1 with bit 4 set. Status bit 3 mirrors it.
- R7: On transmit, a descriptor with bit 30 set gets its count/flag word rewritten at D+4 with bit 15 set. A descriptor without bit 30 is never written.
- R8: Writing control bit 2 as 1 selects receive. Received bytes are packed into words in the selected byte order and written at the buffer address upward. Unused byte lanes of a final partial word are written as zero. Every receive descriptor gets its count/flag word rewritten with bit 14 set.
- R9: A descriptor with a zero byte count makes no buffer access and moves no bytes, but its flags are still handled.
- R10: Writing register 1 with bit 3 set aborts the channel. By the next cycle it is idle, with no memory request, no transmit byte offered and no receive byte accepted, and no further data moves.
- R11: Only one memory access is outstanding at a time. A request holds its address and direction until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 next pointer, 1 control/status) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Access accepted; read data valid in this cycle |
| mem_rdata | input | 32 | Memory read data |
| tx_valid | output | 1 | Transmit byte offered |
| tx_ready | input | 1 | Device accepts the transmit byte |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Byte ends a packet |
| rx_valid | input | 1 | Receive byte offered by the device |
| rx_ready | output | 1 | Engine accepts a receive byte |
| rx_data | input | 8 | Receive byte |
| irq | output | 1 | Channel interrupt |

## Verification
The properties assume that the memory side acknowledges only a raised request, and that a read acknowledge carries valid data in the same cycle. They also assume software changes the byte order and direction only while idle, and that buffer addresses are word aligned. The memory model answers each request once, on alternate cycles, from a word array. All descriptors and buffers are placed on word boundaries, inside that array. The device models hold their bytes until they are taken, and they stall the transmit side only through the ready input.

// File: rtl/desc_dma_pkg.sv
package desc_dma_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FETCH_BUF,
    ST_FETCH_INFO,
    ST_FETCH_NEXT,
    ST_TX_READ,
    ST_TX_SEND,
    ST_RX_TAKE,
    ST_RX_WRITE,
    ST_WRITEBACK,
    ST_FINISH
  } dma_state_e;

  localparam logic [1:0] REG_NEXT = 2'd0;
  localparam logic [1:0] REG_CTRL = 2'd1;

  localparam int CTL_START  = 0;
  localparam int CTL_LITTLE = 1;
  localparam int CTL_RECV   = 2;
  localparam int CTL_CHRST  = 3;
  localparam int CTL_IRQCLR = 4;

  localparam int STS_BUSY   = 0;
  localparam int STS_LITTLE = 1;
  localparam int STS_RECV   = 2;
  localparam int STS_IRQ    = 3;

  localparam int INFO_CHAIN_END = 31;
  localparam int INFO_PKT_END   = 30;
  localparam int INFO_IRQ_EN    = 29;
  localparam int INFO_TX_DONE   = 15;
  localparam int INFO_RX_OWN    = 14;

endpackage

// File: rtl/desc_dma_lane.sv
module desc_dma_lane #(
  parameter int DW = 32
) (
  input  logic [DW-1:0]              word_in,
  input  logic [$clog2(DW/8)-1:0]    idx,
  input  logic                       little,
  input  logic [7:0]                 byte_in,
  output logic [7:0]                 byte_out,
  output logic [DW-1:0]              word_out
);
  localparam int BYTES = DW / 8;
  localparam int LW    = $clog2(BYTES);

  logic [LW-1:0] slot;

  // byte k of the stream lives in slot k (little) or slot BYTES-1-k (big)
  assign slot     = little ? idx : (LW'(BYTES - 1) - idx);
  assign byte_out = word_in[slot*8 +: 8];

  for (genvar g = 0; g < BYTES; g++) begin : g_slot
    assign word_out[g*8 +: 8] = (slot == LW'(g)) ? byte_in : word_in[g*8 +: 8];
  end

endmodule

// File: rtl/desc_dma_regs.sv
module desc_dma_regs
  import desc_dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          busy,
  input  logic          ndp_load,
  input  logic [AW-1:0] ndp_value,
  input  logic          irq_set,
  output logic [AW-1:0] ndp,
  output logic          little,
  output logic          recv,
  output logic          irq,
  output logic          start_pulse,
  output logic          chan_rst
);
  logic          wr_next, wr_ctrl;
  logic [AW-1:0] ndp_q, ndp_d;
  logic          little_q, little_d;
  logic          recv_q, recv_d;
  logic          irq_q, irq_d;

  assign wr_next     = reg_wr && (reg_addr == REG_NEXT);
  assign wr_ctrl     = reg_wr && (reg_addr == REG_CTRL);
  assign start_pulse = wr_ctrl && reg_wdata[CTL_START] && !reg_wdata[CTL_CHRST];
  assign chan_rst    = wr_ctrl && reg_wdata[CTL_CHRST];

  always_comb begin
    ndp_d    = ndp_q;
    little_d = little_q;
    recv_d   = recv_q;
    irq_d    = irq_q;
    if (ndp_load) begin
      ndp_d = ndp_value;
    end else if (wr_next && !busy) begin
      ndp_d = reg_wdata[AW-1:0];
    end
    if (wr_ctrl && !busy) begin
      little_d = reg_wdata[CTL_LITTLE];
      recv_d   = reg_wdata[CTL_RECV];
    end
    if (irq_set) begin
      irq_d = 1'b1;
    end else if (wr_ctrl && reg_wdata[CTL_IRQCLR]) begin
      irq_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ndp_q    <= '0;
      little_q <= 1'b0;
      recv_q   <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      ndp_q    <= ndp_d;
      little_q <= little_d;
      recv_q   <= recv_d;
      irq_q    <= irq_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      REG_NEXT: reg_rdata = DW'(ndp_q);
      REG_CTRL: begin
        reg_rdata[STS_BUSY]   = busy;
        reg_rdata[STS_LITTLE] = little_q;
        reg_rdata[STS_RECV]   = recv_q;
        reg_rdata[STS_IRQ]    = irq_q;
      end
      default: reg_rdata = '0;
    endcase
  end

  assign ndp    = ndp_q;
  assign little = little_q;
  assign recv   = recv_q;
  assign irq    = irq_q;

endmodule

// File: rtl/desc_dma_seq.sv
module desc_dma_seq
  import desc_dma_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CNT_W = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_pulse,
  input  logic          chan_rst,
  input  logic [AW-1:0] ndp,
  input  logic          little,
  input  logic          recv,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [7:0]    rx_data,
  output logic          busy,
  output logic          ndp_load,
  output logic [AW-1:0] ndp_value,
  output logic          irq_set
);
  localparam int          BYTES    = DW / 8;
  localparam int          LW       = $clog2(BYTES);
  localparam logic [AW-1:0] STEP   = AW'(BYTES);
  localparam logic [AW-1:0] OFS_INF = AW'(BYTES);
  localparam logic [AW-1:0] OFS_NXT = AW'(2 * BYTES);

  dma_state_e     state_q, state_d;
  logic [AW-1:0]  desc_q, desc_d;
  logic [AW-1:0]  buf_q, buf_d;
  logic [DW-1:0]  info_q, info_d;
  logic [AW-1:0]  next_q, next_d;
  logic [CNT_W-1:0] remain_q, remain_d;
  logic [LW-1:0]  lane_q, lane_d;
  logic [DW-1:0]  word_q, word_d;

  logic [7:0]     lane_byte;
  logic [DW-1:0]  lane_word;
  logic           last_byte, lane_end, wb_need;
  dma_state_e     after_data;

  desc_dma_lane #(.DW(DW)) u_lane (
    .word_in  (word_q),
    .idx      (lane_q),
    .little   (little),
    .byte_in  (rx_data),
    .byte_out (lane_byte),
    .word_out (lane_word)
  );

  assign last_byte  = (remain_q == CNT_W'(1));
  assign lane_end   = (lane_q == LW'(BYTES - 1));
  assign wb_need    = recv || info_q[INFO_PKT_END];
  assign after_data = wb_need ? ST_WRITEBACK : ST_FINISH;
  assign busy       = (state_q != ST_IDLE);

  always_comb begin
    state_d   = state_q;
    desc_d    = desc_q;
    buf_d     = buf_q;
    info_d    = info_q;
    next_d    = next_q;
    remain_d  = remain_q;
    lane_d    = lane_q;
    word_d    = word_q;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    tx_valid  = 1'b0;
    tx_data   = 8'h00;
    tx_last   = 1'b0;
    rx_ready  = 1'b0;
    ndp_load  = 1'b0;
    ndp_value = next_q;
    irq_set   = 1'b0;

    case (state_q)
      ST_IDLE: begin
        if (start_pulse) begin
          desc_d  = ndp;
          state_d = ST_FETCH_BUF;
        end
      end
      ST_FETCH_BUF: begin
        mem_req  = 1'b1;
        mem_addr = desc_q;
        if (mem_ack) begin
          buf_d   = mem_rdata[AW-1:0];
          state_d = ST_FETCH_INFO;
        end
      end
      ST_FETCH_INFO: begin
        mem_req  = 1'b1;
        mem_addr = desc_q + OFS_INF;
        if (mem_ack) begin
          info_d   = mem_rdata;
          remain_d = mem_rdata[CNT_W-1:0];
          state_d  = ST_FETCH_NEXT;
        end
      end
      ST_FETCH_NEXT: begin
        mem_req  = 1'b1;
        mem_addr = desc_q + OFS_NXT;
        if (mem_ack) begin
          next_d = mem_rdata[AW-1:0];
          lane_d = '0;
          word_d = '0;
          if (remain_q == '0)  state_d = after_data;
          else if (recv)       state_d = ST_RX_TAKE;
          else                 state_d = ST_TX_READ;
        end
      end
      ST_TX_READ: begin
        mem_req  = 1'b1;
        mem_addr = buf_q;
        if (mem_ack) begin
          word_d  = mem_rdata;
          buf_d   = buf_q + STEP;
          lane_d  = '0;
          state_d = ST_TX_SEND;
        end
      end
      ST_TX_SEND: begin
        tx_valid = 1'b1;
        tx_data  = lane_byte;
        tx_last  = last_byte && info_q[INFO_PKT_END];
        if (tx_ready) begin
          remain_d = remain_q - CNT_W'(1);
          lane_d   = lane_q + LW'(1);
          if (last_byte)     state_d = after_data;
          else if (lane_end) state_d = ST_TX_READ;
        end
      end
      ST_RX_TAKE: begin
        rx_ready = 1'b1;
        if (rx_valid) begin
          word_d   = lane_word;
          remain_d = remain_q - CNT_W'(1);
          lane_d   = lane_q + LW'(1);
          if (last_byte || lane_end) state_d = ST_RX_WRITE;
        end
      end
      ST_RX_WRITE: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = buf_q;
        mem_wdata = word_q;
        if (mem_ack) begin
          buf_d   = buf_q + STEP;
          word_d  = '0;
          lane_d  = '0;
          state_d = (remain_q == '0) ? after_data : ST_RX_TAKE;
        end
      end
      ST_WRITEBACK: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = desc_q + OFS_INF;
        mem_wdata = info_q;
        if (recv) mem_wdata[INFO_RX_OWN] = 1'b1;
        else      mem_wdata[INFO_TX_DONE] = 1'b1;
        if (mem_ack) state_d = ST_FINISH;
      end
      ST_FINISH: begin
        ndp_load = 1'b1;
        irq_set  = info_q[INFO_IRQ_EN];
        if (info_q[INFO_CHAIN_END]) begin
          state_d = ST_IDLE;
        end else begin
          desc_d  = next_q;
          state_d = ST_FETCH_BUF;
        end
      end
      default: state_d = ST_IDLE;
    endcase

    if (chan_rst) begin
      state_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      desc_q   <= '0;
      buf_q    <= '0;
      info_q   <= '0;
      next_q   <= '0;
      remain_q <= '0;
      lane_q   <= '0;
      word_q   <= '0;
    end else begin
      state_q  <= state_d;
      desc_q   <= desc_d;
      buf_q    <= buf_d;
      info_q   <= info_d;
      next_q   <= next_d;
      remain_q <= remain_d;
      lane_q   <= lane_d;
      word_q   <= word_d;
    end
  end

endmodule

// File: rtl/desc_dma.sv
module desc_dma
  import desc_dma_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CNT_W = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [7:0]    rx_data,
  output logic          irq
);
  logic          busy;
  logic          ndp_load;
  logic [AW-1:0] ndp_value;
  logic          irq_set;
  logic [AW-1:0] ndp;
  logic          little, recv;
  logic          start_pulse, chan_rst;

  desc_dma_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .busy        (busy),
    .ndp_load    (ndp_load),
    .ndp_value   (ndp_value),
    .irq_set     (irq_set),
    .ndp         (ndp),
    .little      (little),
    .recv        (recv),
    .irq         (irq),
    .start_pulse (start_pulse),
    .chan_rst    (chan_rst)
  );

  desc_dma_seq #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_pulse (start_pulse),
    .chan_rst    (chan_rst),
    .ndp         (ndp),
    .little      (little),
    .recv        (recv),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_ack     (mem_ack),
    .mem_rdata   (mem_rdata),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .tx_data     (tx_data),
    .tx_last     (tx_last),
    .rx_valid    (rx_valid),
    .rx_ready    (rx_ready),
    .rx_data     (rx_data),
    .busy        (busy),
    .ndp_load    (ndp_load),
    .ndp_value   (ndp_value),
    .irq_set     (irq_set)
  );

endmodule

// File: rtl/desc_dma_chk.sv
module desc_dma_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [1:0]    reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ack,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [7:0]    tx_data,
  input logic          tx_last,
  input logic          rx_ready,
  input logic          irq,
  input logic          busy
);
  logic ctl_wr, abort_wr;
  assign ctl_wr   = reg_wr && (reg_addr == 2'd1);
  assign abort_wr = ctl_wr && reg_wdata[3];

  assert_req_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !abort_wr) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  assert_tx_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !abort_wr) |=> (tx_valid && $stable(tx_data)));

  assert_last_with_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ctl_wr && reg_wdata[0] && !reg_wdata[3]) |=> busy);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !tx_valid && !rx_ready));

  assert_abort_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    abort_wr |=> (!busy && !mem_req && !tx_valid && !rx_ready));

  assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(ctl_wr && reg_wdata[4])) |=> irq);

endmodule

bind desc_dma desc_dma_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/desc_dma_tb.sv
`timescale 1ns/1ps
module desc_dma_tb;
  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        tx_valid, tx_ready, tx_last;
  logic [7:0]  tx_data;
  logic        rx_valid, rx_ready;
  logic [7:0]  rx_data;
  logic        irq;

  int checks = 0;
  int failures = 0;

  logic [31:0] mem_arr [0:255];
  int          ack_cnt, watch_cnt;
  logic [31:0] watch_addr;

  logic [7:0]  tx_log [0:63];
  int          tx_cnt, tx_last_cnt, tx_last_idx;
  bit          tx_hold, tx_stall;

  logic [7:0]  rx_src [0:15];
  int          rx_len, rx_idx;
  bit          rx_take;

  desc_dma u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .irq(irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // memory: one acknowledge per request, on alternate cycles
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 1'b0;
    end else if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req) begin
      mem_ack = 1'b1;
      ack_cnt++;
      if (!mem_we && mem_addr == watch_addr) watch_cnt++;
      if (mem_we) mem_arr[mem_addr[9:2]] = mem_wdata;
      mem_rdata = mem_arr[mem_addr[9:2]];
    end
  end

  // transmit device
  always @(negedge clk) begin
    tx_ready = tx_hold ? 1'b0 : (tx_stall ? ~tx_ready : 1'b1);
    if (rst_n && tx_valid && tx_ready) begin
      if (tx_cnt < 64) tx_log[tx_cnt] = tx_data;
      if (tx_last) begin
        tx_last_cnt++;
        tx_last_idx = tx_cnt;
      end
      tx_cnt++;
    end
  end

  // receive device
  always @(negedge clk) begin
    if (rx_take) rx_idx++;
    rx_valid = rst_n && (rx_idx < rx_len);
    rx_data  = (rx_idx < rx_len) ? rx_src[rx_idx] : 8'h00;
    rx_take  = rx_valid && rx_ready;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #0.5 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 4000; i++) begin
      reg_read(2'd1, s);
      if (!s[0]) return;
    end
  endtask

  task automatic put(input logic [31:0] a, input logic [31:0] d);
    mem_arr[a[9:2]] = d;
  endtask

  task automatic clear_logs();
    tx_cnt = 0; tx_last_cnt = 0; tx_last_idx = -1;
    ack_cnt = 0; watch_cnt = 0;
    for (int i = 0; i < 256; i++) mem_arr[i] = 32'h0;
  endtask

  function automatic logic [7:0] pick(input logic [31:0] w, input int k, input bit little);
    return little ? w[8*k +: 8] : w[8*(3-k) +: 8];
  endfunction

  task automatic run(input logic [31:0] desc, input logic [31:0] ctl);
    reg_write(2'd0, desc);
    reg_write(2'd1, ctl | 32'h1);
    wait_idle();
  endtask

  task automatic t_reset_state();
    logic [31:0] s, n;
    reg_read(2'd1, s);
    reg_read(2'd0, n);
    check("R2 status after reset", s, 32'h0);
    check("R2 next pointer after reset", n, 32'h0);
    check("R10 outputs quiet after reset", {mem_req, tx_valid, rx_ready, irq}, 4'h0);
  endtask

  task automatic t_tx_single_big();
    logic [31:0] s;
    clear_logs();
    put(32'h40, 32'h100); put(32'h44, 32'hE000_0006); put(32'h48, 32'h0);
    put(32'h100, 32'h1122_3344); put(32'h104, 32'h5566_7788);
    run(32'h40, 32'h0);
    check("R3 byte count", tx_cnt, 6);
    for (int k = 0; k < 6; k++)
      check("R3 big-endian byte", tx_log[k], pick(mem_arr[64 + k/4], k % 4, 1'b0));
    check("R4 single end-of-packet", tx_last_cnt, 1);
    check("R4 end-of-packet on final byte", tx_last_idx, 5);
    check("R7 done bit written back", mem_arr[17], 32'hE000_8006);
    check("R1 R11 one access per step (3 fetch, 2 data, 1 status)", ack_cnt, 6);
    check("R6 irq raised", irq, 1'b1);
    reg_read(2'd1, s);
    check("R5 busy cleared at chain end", s[0], 1'b0);
    check("R6 status mirrors irq", s[3], 1'b1);
    reg_write(2'd1, 32'h10);
    check("R6 irq cleared by control", irq, 1'b0);
  endtask

  task automatic t_tx_chain_little();
    logic [31:0] n;
    clear_logs();
    tx_stall = 1'b1;
    put(32'h40, 32'h100); put(32'h44, 32'h0000_0003); put(32'h48, 32'h80);
    put(32'h80, 32'h180); put(32'h84, 32'hC000_0005); put(32'h88, 32'h2C0);
    put(32'h100, 32'hA1B2_C3D4);
    put(32'h180, 32'h0102_0304); put(32'h184, 32'h0506_0708);
    run(32'h40, 32'h2);
    tx_stall = 1'b0;
    check("R5 bytes across two descriptors", tx_cnt, 8);
    for (int k = 0; k < 3; k++)
      check("R3 little-endian first buffer", tx_log[k], pick(32'hA1B2_C3D4, k, 1'b1));
    for (int k = 0; k < 5; k++)
      check("R3 little-endian second buffer", tx_log[3+k], pick(mem_arr[96 + k/4], k % 4, 1'b1));
    check("R4 no marker without flag", tx_last_cnt, 1);
    check("R4 marker only at chain end", tx_last_idx, 7);
    check("R7 no write-back without end-of-packet", mem_arr[17], 32'h0000_0003);
    check("R7 write-back on packet end", mem_arr[33], 32'hC000_8005);
    check("R6 no irq without enable", irq, 1'b0);
    reg_read(2'd0, n);
    check("R5 next pointer follows chain", n, 32'h2C0);
  endtask

  task automatic t_zero_skip();
    clear_logs();
    watch_addr = 32'h100;
    put(32'h40, 32'h100); put(32'h44, 32'h2000_0000); put(32'h48, 32'h80);
    put(32'h80, 32'h180); put(32'h84, 32'hC000_0002); put(32'h88, 32'h0);
    put(32'h100, 32'hDEAD_BEEF); put(32'h180, 32'h0102_0304);
    run(32'h40, 32'h0);
    check("R9 zero-count buffer untouched", watch_cnt, 0);
    check("R9 only next buffer bytes", tx_cnt, 2);
    check("R9 next buffer first byte", tx_log[0], 8'h01);
    check("R9 flags handled (irq)", irq, 1'b1);
    reg_write(2'd1, 32'h10);
    watch_addr = 32'hFFFF_FFFF;
  endtask

  task automatic t_rx();
    clear_logs();
    put(32'h40, 32'h200); put(32'h44, 32'hA000_0006); put(32'h48, 32'h0);
    put(32'h200, 32'hFFFF_FFFF); put(32'h204, 32'hFFFF_FFFF);
    rx_src[0] = 8'h9A; rx_src[1] = 8'hBC; rx_src[2] = 8'hDE;
    rx_src[3] = 8'hF0; rx_src[4] = 8'h12; rx_src[5] = 8'h34;
    rx_idx = 0; rx_len = 6;
    run(32'h40, 32'h4);
    check("R8 full word big-endian", mem_arr[128], 32'h9ABC_DEF0);
    check("R8 partial word zero padded", mem_arr[129], 32'h1234_0000);
    check("R8 ownership written back", mem_arr[17], 32'hA000_4006);
    check("R8 all bytes taken", rx_idx, 6);
    reg_write(2'd1, 32'h10);
    clear_logs();
    put(32'h40, 32'h200); put(32'h44, 32'h8000_0003); put(32'h48, 32'h0);
    put(32'h200, 32'hFFFF_FFFF);
    rx_src[0] = 8'h11; rx_src[1] = 8'h22; rx_src[2] = 8'h33;
    rx_idx = 0; rx_len = 3;
    run(32'h40, 32'h6);
    check("R8 little-endian partial word", mem_arr[128], 32'h0033_2211);
    check("R8 ownership without other flags", mem_arr[17], 32'h8000_4003);
    rx_len = 0; rx_idx = 0;
  endtask

  task automatic t_abort();
    logic [31:0] s;
    clear_logs();
    tx_hold = 1'b1;
    put(32'h40, 32'h100); put(32'h44, 32'hE000_0004); put(32'h48, 32'h0);
    put(32'h100, 32'h0A0B_0C0D);
    reg_write(2'd0, 32'h40);
    reg_write(2'd1, 32'h1);
    repeat (20) @(negedge clk);
    check("R10 stalled before abort", tx_valid, 1'b1);
    reg_write(2'd1, 32'h8);
    reg_read(2'd1, s);
    check("R10 busy cleared by abort", s[0], 1'b0);
    check("R10 no request after abort", {mem_req, tx_valid}, 2'b00);
    tx_hold = 1'b0;
    repeat (10) @(negedge clk);
    check("R10 no bytes after abort", tx_cnt, 0);
    check("R10 abort leaves irq low", irq, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
    tx_hold = 1'b0; tx_stall = 1'b0; tx_ready = 1'b0;
    rx_len = 0; rx_idx = 0; rx_take = 1'b0; rx_valid = 1'b0; rx_data = 8'h00;
    mem_ack = 1'b0; mem_rdata = '0; watch_addr = 32'hFFFF_FFFF;
    clear_logs();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_tx_single_big();
    t_tx_chain_little();
    t_zero_skip();
    t_rx();
    t_abort();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule